// File: doc/BRIEF.md
# Poisoning ECC Word Store

A small word-addressed memory that guards each stored word with single-error-correct, double-error-detect check bits. Beside each word it keeps a one-bit poison mark. Writers deliver a data word together with the check bits they already hold for it, plus a poison sideband. A typical writer is a cache that is evicting a line and has found that line damaged beyond repair. The store checks the incoming codeword. A damaged word, or one the writer flags, is recorded as poisoned and the write completes quietly, with no fault at that time.

Reads are registered and take one cycle. The read path decodes the stored codeword and repairs a single flipped bit, raising a correction indication when it does so. It returns the poison mark with the data. When the word is poisoned, or cannot be decoded, it emits a one-cycle fault strobe. The fault therefore reaches the master that actually consumes the bad data, and only when that master reads it. A clean write over a poisoned word removes the mark, and that word never causes a fault.

Top module: `pmem_ecc_poison`

## Requirements
- R1: After reset every word reads back as data 0 with no poison, no fault and no correction. All read outputs are low until the first read.
- R2: A read issued with `rd_en` high in cycle t presents `rd_valid` and the response in cycle t+1 only. A clean write followed by a read returns the written data unchanged.
- R3: The check bits are defined as follows. Data bits sit at the codeword positions 1..38 that are not powers of two, in ascending order; data bit 0 is at position 3. Check bit k (k = 0..5) is the XOR of all data bits whose position has bit k set. Check bit 6 is the XOR of all data bits and check bits 0..5. A single flipped bit anywhere in the stored codeword (data, check or overall) is repaired on read, with `rd_corrected` high, and no poison or fault is reported.
- R4: A write whose codeword carries a two-bit error stores the word as poisoned and raises no fault during the write.
- R5: A write with `wr_poison` high stores the word as poisoned, whatever its check bits, and raises no fault during the write.
- R6: A read of a poisoned word returns `rd_poison` high and a `rd_fault` pulse lasting exactly the one response cycle.
- R7: A write with `wr_poison` low and a codeword that has no uncorrectable error clears the poison mark. A later read of that word reports neither poison nor fault, even if the word was poisoned before and never read.
- R8: `rd_fault` is never high outside a response cycle.
- R9: When a read and a write target the same address in the same cycle, the read returns the contents from before the write.
- R10: `rd_corrected` is never reported together with `rd_poison`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (4) | Write word address |
| wr_data | input | DATA_W (32) | Write data |
| wr_ecc | input | ECC_W (7) | Check bits delivered with the write data |
| wr_poison | input | 1 | Writer marks the word as poisoned |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (4) | Read word address |
| rd_valid | output | 1 | Read response present |
| rd_data | output | DATA_W (32) | Read data after correction |
| rd_poison | output | 1 | Returned word is poisoned |
| rd_fault | output | 1 | One-cycle fault strobe for the reading master |
| rd_corrected | output | 1 | A single-bit error was repaired in this response |

## Verification
Clean codewords with sparse, dense and all-ones data establish that decoding leaves correct words untouched. Single flips are then applied in a data bit, in a check bit and in the overall parity bit. Each location exercises a different branch of the syndrome decode, and each must produce repaired data with the correction flag. Two-bit flips and the poison sideband are applied separately, so that detected corruption and writer-declared poison are each shown to defer the fault until a read. Clean overwrites of poisoned words, with and without an intervening read, and a read colliding with a write to the same address complete the set.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  // Outcome of decoding one codeword
  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_MULTI  = 2'd2
  } err_class_e;

  // Number of Hamming check bits needed to cover dw data bits
  function automatic int hamming_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Codeword position (1-based) of data bit idx: skips powers of two
  function automatic int data_pos(input int idx);
    int pos;
    int seen;
    pos  = 0;
    seen = -1;
    while (seen < idx) begin
      pos++;
      if ((pos & (pos - 1)) != 0) seen++;
    end
    return pos;
  endfunction

endpackage

// File: rtl/pmem_secded_classify.sv
module pmem_secded_classify #(
  parameter int DATA_W = 32,
  parameter int SYN_W  = pmem_pkg::hamming_bits(DATA_W)
) (
  input  logic [DATA_W-1:0]        data_i,
  input  logic [SYN_W:0]           ecc_i,
  output logic [SYN_W-1:0]         syn_o,
  output pmem_pkg::err_class_e     cls_o
);
  import pmem_pkg::*;

  localparam int CW_N = DATA_W + SYN_W;

  logic [SYN_W-1:0] contrib [DATA_W];
  logic             overall;

  // Each set data bit contributes its codeword position to the syndrome
  for (genvar g = 0; g < DATA_W; g++) begin : g_contrib
    localparam int POS = data_pos(g);
    assign contrib[g] = data_i[g] ? SYN_W'(POS) : '0;
  end

  always_comb begin
    syn_o = ecc_i[SYN_W-1:0];
    for (int i = 0; i < DATA_W; i++) syn_o = syn_o ^ contrib[i];
  end

  assign overall = ^{data_i, ecc_i};

  always_comb begin
    if (!overall) cls_o = (syn_o == '0) ? ERR_NONE : ERR_MULTI;
    else          cls_o = (int'(syn_o) <= CW_N) ? ERR_SINGLE : ERR_MULTI;
  end

endmodule

// File: rtl/pmem_secded_fix.sv
module pmem_secded_fix #(
  parameter int DATA_W = 32,
  parameter int SYN_W  = pmem_pkg::hamming_bits(DATA_W)
) (
  input  logic [DATA_W-1:0]     data_i,
  input  logic [SYN_W-1:0]      syn_i,
  input  pmem_pkg::err_class_e  cls_i,
  output logic [DATA_W-1:0]     data_o
);
  import pmem_pkg::*;

  logic single_hit;
  assign single_hit = (cls_i == ERR_SINGLE);

  // Flip the one data bit the syndrome points at
  for (genvar g = 0; g < DATA_W; g++) begin : g_fix
    localparam int POS = data_pos(g);
    assign data_o[g] = data_i[g] ^ (single_hit && (syn_i == SYN_W'(POS)));
  end

endmodule

// File: rtl/pmem_store.sv
module pmem_store #(
  parameter int DATA_W = 32,
  parameter int ECC_W  = 7,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ECC_W-1:0]  wr_ecc,
  input  logic              wr_mark,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ECC_W-1:0]  rd_ecc,
  output logic              rd_mark,
  output logic [DEPTH-1:0]  mark_vec
);

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [ECC_W-1:0]  mem_e [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_d[i] <= '0;
        mem_e[i] <= '0;
      end
      mark_vec <= '0;
    end else if (wr_en) begin
      mem_d[wr_addr]    <= wr_data;
      mem_e[wr_addr]    <= wr_ecc;
      mark_vec[wr_addr] <= wr_mark;
    end
  end

  // Combinational read: old contents are seen during a colliding write
  assign rd_data = mem_d[rd_addr];
  assign rd_ecc  = mem_e[rd_addr];
  assign rd_mark = mark_vec[rd_addr];

endmodule

// File: rtl/pmem_ecc_poison.sv
module pmem_ecc_poison #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 16,
  localparam int SYN_W  = pmem_pkg::hamming_bits(DATA_W),
  localparam int ECC_W  = SYN_W + 1,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ECC_W-1:0]  wr_ecc,
  input  logic              wr_poison,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_poison,
  output logic              rd_fault,
  output logic              rd_corrected
);
  import pmem_pkg::*;

  // ---------------- write side: classify incoming codeword
  logic [SYN_W-1:0] wr_syn;
  err_class_e       wr_cls;
  logic             wr_mark;

  pmem_secded_classify #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_wr_cls (
    .data_i (wr_data),
    .ecc_i  (wr_ecc),
    .syn_o  (wr_syn),
    .cls_o  (wr_cls)
  );

  // Uncorrectable on write-back is deferred as poison, never a fault here
  assign wr_mark = wr_poison || (wr_cls == ERR_MULTI);

  // ---------------- storage
  logic [DATA_W-1:0] st_data;
  logic [ECC_W-1:0]  st_ecc;
  logic              st_mark;
  logic [DEPTH-1:0]  mark_vec;

  pmem_store #(.DATA_W(DATA_W), .ECC_W(ECC_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ecc   (wr_ecc),
    .wr_mark  (wr_mark),
    .rd_addr  (rd_addr),
    .rd_data  (st_data),
    .rd_ecc   (st_ecc),
    .rd_mark  (st_mark),
    .mark_vec (mark_vec)
  );

  // ---------------- read side: decode, repair, register
  logic [SYN_W-1:0]  rd_syn;
  err_class_e        rd_cls;
  logic [DATA_W-1:0] rd_fixed;
  logic              rd_bad;
  logic              rd_repair;

  pmem_secded_classify #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_rd_cls (
    .data_i (st_data),
    .ecc_i  (st_ecc),
    .syn_o  (rd_syn),
    .cls_o  (rd_cls)
  );

  pmem_secded_fix #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_rd_fix (
    .data_i (st_data),
    .syn_i  (rd_syn),
    .cls_i  (rd_cls),
    .data_o (rd_fixed)
  );

  assign rd_bad    = st_mark || (rd_cls == ERR_MULTI);
  assign rd_repair = (rd_cls == ERR_SINGLE) && !rd_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rd_poison    <= 1'b0;
      rd_fault     <= 1'b0;
      rd_corrected <= 1'b0;
    end else begin
      rd_valid     <= rd_en;
      rd_data      <= rd_en ? rd_fixed : '0;
      rd_poison    <= rd_en && rd_bad;
      rd_fault     <= rd_en && rd_bad;
      rd_corrected <= rd_en && rd_repair;
    end
  end

  // ---------------- assertions
  p_resp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_no_resp_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_fault_in_resp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> rd_valid);

  p_write_raises_no_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |=> !rd_fault);

  p_multi_poisons_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cls == ERR_MULTI) |=> mark_vec[$past(wr_addr)]);

  p_sideband_poisons_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_poison) |=> mark_vec[$past(wr_addr)]);

  p_clean_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_poison && wr_cls == ERR_NONE) |=> !mark_vec[$past(wr_addr)]);

  p_clean_has_zero_syn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cls == ERR_NONE) |-> (wr_syn == '0));

  p_repair_excludes_poison_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_corrected |-> !rd_poison);

  p_fault_is_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fault && !rd_en) |=> !rd_fault);

endmodule

// File: tb/pmem_ecc_poison_tb.sv
module pmem_ecc_poison_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [6:0]  wr_ecc;
  logic        wr_poison;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_poison;
  logic        rd_fault;
  logic        rd_corrected;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  pmem_ecc_poison u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .wr_ecc       (wr_ecc),
    .wr_poison    (wr_poison),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_poison    (rd_poison),
    .rd_fault     (rd_fault),
    .rd_corrected (rd_corrected)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // Bench-side check bits: XOR of the positions of all set data bits
  function automatic logic [6:0] tb_ecc(input logic [31:0] d);
    logic [6:0] c;
    int pos;
    int di;
    c = '0;
    pos = 0;
    di = 0;
    while (di < 32) begin
      pos++;
      if ((pos & (pos - 1)) != 0) begin
        if (d[di]) c[5:0] = c[5:0] ^ 6'(pos);
        di++;
      end
    end
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d,
                          input logic [6:0] e, input logic p);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_ecc = e; wr_poison = p;
    @(negedge clk);
    wr_en = 0; wr_poison = 0;
  endtask

  // Issues a read and returns at the negedge where the response is held
  task automatic do_read(input logic [3:0] a);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset_state;
    check("R1", "valid after reset", {31'd0, rd_valid}, 32'd0);
    check("R1", "fault after reset", {31'd0, rd_fault}, 32'd0);
    do_read(4'd5);
    check("R1", "data", rd_data, 32'd0);
    check("R1", "poison", {31'd0, rd_poison}, 32'd0);
    check("R1", "fault", {31'd0, rd_fault}, 32'd0);
    check("R1", "corrected", {31'd0, rd_corrected}, 32'd0);
  endtask

  task automatic t_clean_rw;
    logic [31:0] pats [3];
    pats[0] = 32'hA5A5_1234; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0001;
    for (int i = 0; i < 3; i++) do_write(4'(i * 7 + 1), pats[i], tb_ecc(pats[i]), 0);
    for (int i = 0; i < 3; i++) begin
      do_read(4'(i * 7 + 1));
      check("R2", "valid", {31'd0, rd_valid}, 32'd1);
      check("R2", "data", rd_data, pats[i]);
      check("R2", "flags", {29'd0, rd_poison, rd_fault, rd_corrected}, 32'd0);
    end
    @(negedge clk);
    check("R2", "valid after idle", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_single_err;
    logic [31:0] d;
    d = 32'h1357_9BDF;
    do_write(4'd2, d ^ 32'h0000_0080, tb_ecc(d), 0);
    do_read(4'd2);
    check("R3", "data bit fixed", rd_data, d);
    check("R3", "corrected", {31'd0, rd_corrected}, 32'd1);
    check("R3", "no poison", {30'd0, rd_poison, rd_fault}, 32'd0);
    do_write(4'd2, d, tb_ecc(d) ^ 7'h08, 0);
    do_read(4'd2);
    check("R3", "check bit flip data", rd_data, d);
    check("R3", "check bit flip corrected", {31'd0, rd_corrected}, 32'd1);
    do_write(4'd2, d, tb_ecc(d) ^ 7'h40, 0);
    do_read(4'd2);
    check("R3", "overall flip data", rd_data, d);
    check("R3", "overall flip corrected", {31'd0, rd_corrected}, 32'd1);
    check("R3", "overall flip fault", {31'd0, rd_fault}, 32'd0);
  endtask

  task automatic t_double_err;
    logic [31:0] d;
    d = 32'hCAFE_0042;
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd3; wr_data = d ^ 32'h0010_0001; wr_ecc = tb_ecc(d); wr_poison = 0;
    @(negedge clk);
    wr_en = 0;
    check("R4", "no fault at write", {30'd0, rd_valid, rd_fault}, 32'd0);
    @(negedge clk);
    check("R8", "no fault without read", {30'd0, rd_valid, rd_fault}, 32'd0);
    do_read(4'd3);
    check("R6", "poison on read", {31'd0, rd_poison}, 32'd1);
    check("R6", "fault on read", {31'd0, rd_fault}, 32'd1);
    @(negedge clk);
    check("R6", "fault one cycle", {31'd0, rd_fault}, 32'd0);
  endtask

  task automatic t_sideband;
    logic [31:0] d;
    d = 32'h0BAD_F00D;
    do_write(4'd4, d, tb_ecc(d), 1);
    check("R5", "no fault at write", {31'd0, rd_fault}, 32'd0);
    do_read(4'd4);
    check("R5", "poison", {31'd0, rd_poison}, 32'd1);
    check("R6", "fault", {31'd0, rd_fault}, 32'd1);
    check("R5", "data passed", rd_data, d);
    do_write(4'd9, d ^ 32'h0000_0004, tb_ecc(d), 1);
    do_read(4'd9);
    check("R10", "poison with single flip", {31'd0, rd_poison}, 32'd1);
    check("R10", "no correction on poison", {31'd0, rd_corrected}, 32'd0);
  endtask

  task automatic t_overwrite;
    logic [31:0] d;
    d = 32'h600D_D47A;
    do_write(4'd4, d, tb_ecc(d), 0);
    do_read(4'd4);
    check("R7", "read after clean overwrite", rd_data, d);
    check("R7", "poison cleared", {30'd0, rd_poison, rd_fault}, 32'd0);
    do_write(4'd6, 32'h1, tb_ecc(32'h1) ^ 7'h03, 0);
    do_write(4'd6, d, tb_ecc(d), 0);
    do_read(4'd6);
    check("R7", "unread poison overwritten", {30'd0, rd_poison, rd_fault}, 32'd0);
    check("R7", "overwrite data", rd_data, d);
  endtask

  task automatic t_collision;
    logic [31:0] nd;
    nd = 32'h7777_0000;
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd1; wr_data = nd; wr_ecc = tb_ecc(nd); wr_poison = 0;
    rd_en = 1; rd_addr = 4'd1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R9", "old data on collision", rd_data, 32'hA5A5_1234);
    do_read(4'd1);
    check("R9", "new data afterwards", rd_data, nd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog (all): actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_ecc = 0; wr_poison = 0;
    rd_en = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_clean_rw();
    t_single_err();
    t_double_err();
    t_sideband();
    t_overwrite();
    t_collision();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule